// File: doc/BRIEF.md
# Mode-Selected Dead-Time Generator

This block turns one PWM logic input into two complementary gate enables for a half-bridge. The high-side enable follows the input's phase and the low-side enable is its complement. At every input transition the side that was on is switched off at once, and the opposite side is switched on only after a programmed non-overlap gap. The gap is counted in cycles of a fixed-frequency clock.

The length of the gap comes from a 4-bit thermometer code produced by external comparators. Each comparator reports whether a control voltage sits above one of four rising thresholds. The four valid code bands select four preset gaps. The band below the lowest threshold, and any code that is not a proper thermometer code, forces a shutdown in which both enables are held low together. This is the only way to hold both switches off at the same time.

A new code takes effect only at the next input transition, or when the block leaves shutdown. A gap that is already being counted keeps the length it was loaded with.

Top module: `deadband_gen`

## Requirements
- R1: Once the gap has elapsed and the input is steady, `ho` equals `pwm_in` and `lo` equals its inverse.
- R2: Each turn-on is preceded by a gap of exactly N clock cycles in which both outputs are low. N depends on `mode_therm` (bit 3 is the highest threshold): 4'b1111 gives 3 cycles, 4'b0111 gives 5, 4'b0011 gives 7 and 4'b0001 gives 9. These are the default parameters, which correspond to 15/25/35/45 ns at 200 MHz.
- R3: The side that is on goes low after the first clock edge that samples the changed input.
- R4: A change of `mode_therm` between valid codes has no effect on steady outputs and does not alter a gap already in progress. It sets the gap length only from the next input transition or the next exit from shutdown.
- R5: `mode_therm` = 4'b0000, or any non-monotonic code such as 4'b0101 or 4'b1011, drives both outputs low after the next clock edge. Both stay low whatever `pwm_in` does, for as long as the code persists.
- R6: On leaving shutdown, and on leaving reset, both outputs stay low for the N cycles of the new code. After that the side that matches `pwm_in` turns on.
- R7: If the input changes again while a gap is being counted, the count restarts. A full N-cycle gap is then measured from the later transition.
- R8: `ho` and `lo` are never high in the same cycle.
- R9: `rst_n` is a synchronous active-low reset. While it is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock; all gaps are counted in its cycles |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_in | input | 1 | PWM command; high requests the high side |
| mode_therm | input | 4 | Comparator thermometer code selecting gap or shutdown |
| ho | output | 1 | High-side gate enable, registered |
| lo | output | 1 | Low-side gate enable, registered |

## Verification
On every cycle, the assertions check that the two outputs never overlap. They also check that a shutdown code clears both outputs on the next edge, and that a conducting side drops on the edge after the input leaves it. Two further properties hold on every cycle: a turn-on always matches the sampled input phase, and every loaded gap length is one of the four presets. Only the bench scenarios can show that the gap is exactly the right number of cycles for each code. They also show that a mode change is deferred and never shortens a running count, that a toggle-back restarts the gap, and that the exit from shutdown waits out the new gap.

// File: rtl/deadband_pkg.sv
package deadband_pkg;

  localparam int unsigned DB_LEVELS = 4;

  typedef enum logic [2:0] {
    DB_SHUT = 3'd0,
    DB_P0   = 3'd1,
    DB_P1   = 3'd2,
    DB_P2   = 3'd3,
    DB_P3   = 3'd4
  } db_mode_e;

  function automatic int unsigned db_max4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/deadband_mode_dec.sv
module deadband_mode_dec
  import deadband_pkg::*;
(
  input  logic [DB_LEVELS-1:0] therm,
  output db_mode_e             mode,
  output logic                 shut
);

  // A code is a proper thermometer when no set bit has a clear bit below it.
  logic [DB_LEVELS-2:0] pair_ok;
  logic                 monotonic;
  int unsigned          ones;

  genvar g;
  generate
    for (g = 0; g < DB_LEVELS - 1; g++) begin : g_pair
      assign pair_ok[g] = therm[g] | ~therm[g+1];
    end
  endgenerate

  assign monotonic = &pair_ok;

  always_comb begin
    ones = 0;
    for (int i = 0; i < DB_LEVELS; i++) begin
      ones = ones + int'(therm[i]);
    end
  end

  always_comb begin
    mode = DB_SHUT;
    if (monotonic) begin
      case (ones)
        4:       mode = DB_P0;
        3:       mode = DB_P1;
        2:       mode = DB_P2;
        1:       mode = DB_P3;
        default: mode = DB_SHUT;
      endcase
    end
  end

  assign shut = (mode == DB_SHUT);

endmodule

// File: rtl/deadband_timer.sv
module deadband_timer
  import deadband_pkg::*;
#(
  parameter int unsigned GAP_P0 = 3,
  parameter int unsigned GAP_P1 = 5,
  parameter int unsigned GAP_P2 = 7,
  parameter int unsigned GAP_P3 = 9
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  logic     clear,
  input  db_mode_e sel,
  output logic     expire
);

  localparam int unsigned GAP_MAX = db_max4(GAP_P0, GAP_P1, GAP_P2, GAP_P3);
  localparam int unsigned CNT_W   = $clog2(GAP_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len;

  // The length is captured at load time, so a later code change cannot alter a running gap.
  always_comb begin
    case (sel)
      DB_P0:   len = CNT_W'(GAP_P0);
      DB_P1:   len = CNT_W'(GAP_P1);
      DB_P2:   len = CNT_W'(GAP_P2);
      DB_P3:   len = CNT_W'(GAP_P3);
      default: len = CNT_W'(GAP_P3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = (cnt == CNT_W'(1));

  // R2: every loaded gap is one of the four presets
  p_loaded_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> (cnt == CNT_W'(GAP_P0) || cnt == CNT_W'(GAP_P1) ||
                          cnt == CNT_W'(GAP_P2) || cnt == CNT_W'(GAP_P3)));

endmodule

// File: rtl/deadband_gate.sv
module deadband_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  input  logic shut,
  input  logic expire,
  output logic load,
  output logic clear,
  output logic ho,
  output logic lo
);

  logic pwm_prev;
  logic in_shut;
  logic target;
  logic edge_seen;

  assign edge_seen = (pwm_in != pwm_prev);
  assign clear     = shut;
  assign load      = !shut && (in_shut || edge_seen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_prev <= 1'b0;
      in_shut  <= 1'b1;
      target   <= 1'b0;
      ho       <= 1'b0;
      lo       <= 1'b0;
    end else begin
      pwm_prev <= pwm_in;
      if (shut) begin
        in_shut <= 1'b1;
        ho      <= 1'b0;
        lo      <= 1'b0;
      end else if (load) begin
        in_shut <= 1'b0;
        target  <= pwm_in;
        ho      <= 1'b0;
        lo      <= 1'b0;
      end else if (expire) begin
        ho <= target;
        lo <= ~target;
      end
    end
  end

  // R8: complementary outputs never overlap
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n) !(ho && lo));

  // R5: a shutdown code clears both outputs on the next edge
  p_shut_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shut |=> (!ho && !lo));

  // R3: a conducting side drops once the input leaves it
  p_hi_turnoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ho && !pwm_in) |=> !ho);
  p_lo_turnoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lo && pwm_in) |=> !lo);

  // R1: a turn-on matches the phase of the sampled input
  p_hi_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ho) |-> $past(pwm_in));
  p_lo_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo) |-> !$past(pwm_in));

endmodule

// File: rtl/deadband_gen.sv
module deadband_gen
  import deadband_pkg::*;
#(
  parameter int unsigned GAP_P0 = 3,
  parameter int unsigned GAP_P1 = 5,
  parameter int unsigned GAP_P2 = 7,
  parameter int unsigned GAP_P3 = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwm_in,
  input  logic [DB_LEVELS-1:0] mode_therm,
  output logic                 ho,
  output logic                 lo
);

  db_mode_e mode;
  logic     shut;
  logic     load;
  logic     clear;
  logic     expire;

  deadband_mode_dec u_dec (
    .therm (mode_therm),
    .mode  (mode),
    .shut  (shut)
  );

  deadband_timer #(
    .GAP_P0 (GAP_P0),
    .GAP_P1 (GAP_P1),
    .GAP_P2 (GAP_P2),
    .GAP_P3 (GAP_P3)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .clear  (clear),
    .sel    (mode),
    .expire (expire)
  );

  deadband_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwm_in (pwm_in),
    .shut   (shut),
    .expire (expire),
    .load   (load),
    .clear  (clear),
    .ho     (ho),
    .lo     (lo)
  );

  // R9: both outputs low on the edge after reset is sampled
  p_reset_low_r9: assert property (@(posedge clk) !rst_n |=> (!ho && !lo));

endmodule

// File: tb/tb_deadband_gen.sv
`timescale 1ns/1ps
module tb_deadband_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_in = 1'b0;
  logic [3:0] mode_therm = 4'b1111;
  logic       ho;
  logic       lo;

  int checks = 0;
  int errors = 0;
  int overlap_seen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  deadband_gen dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_in     (pwm_in),
    .mode_therm (mode_therm),
    .ho         (ho),
    .lo         (lo)
  );

  always @(negedge clk) begin
    if (rst_n && ho && lo) overlap_seen++;
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [1:0] exp_hl);
    checks++;
    if ({ho, lo} !== exp_hl) begin
      errors++;
      $display("FAIL %s: {ho,lo} actual %b expected %b at %0t", req, {ho, lo}, exp_hl, $time);
    end
  endtask

  // Called right after new inputs are applied at a negedge.
  task automatic expect_gap(input string req, input int n, input bit hi_side);
    step();
    chk("R3", 2'b00);
    for (int i = 2; i <= n; i++) begin
      step();
      chk(req, 2'b00);
    end
    step();
    chk(req, hi_side ? 2'b10 : 2'b01);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R9", 2'b00);
    end
    rst_n = 1'b1;
    expect_gap("R6", 3, 1'b0);
    step();
    chk("R1", 2'b01);
  endtask

  task automatic t_presets();
    logic [3:0] codes [4] = '{4'b1111, 4'b0111, 4'b0011, 4'b0001};
    int         gaps  [4] = '{3, 5, 7, 9};
    for (int k = 0; k < 4; k++) begin
      mode_therm = codes[k];
      for (int i = 0; i < 3; i++) begin
        step();
        chk("R4", 2'b01);
      end
      pwm_in = 1'b1;
      expect_gap("R2", gaps[k], 1'b1);
      step();
      chk("R1", 2'b10);
      pwm_in = 1'b0;
      expect_gap("R2", gaps[k], 1'b0);
    end
  endtask

  task automatic t_no_shorten();
    pwm_in = 1'b1;
    step();
    chk("R3", 2'b00);
    step();
    chk("R4", 2'b00);
    mode_therm = 4'b1111;
    for (int i = 3; i <= 9; i++) begin
      step();
      chk("R4", 2'b00);
    end
    step();
    chk("R4", 2'b10);
    pwm_in = 1'b0;
    expect_gap("R4", 3, 1'b0);
  endtask

  task automatic t_toggle_back();
    mode_therm = 4'b0001;
    step();
    chk("R4", 2'b01);
    pwm_in = 1'b1;
    step();
    chk("R3", 2'b00);
    step();
    chk("R7", 2'b00);
    pwm_in = 1'b0;
    expect_gap("R7", 9, 1'b0);
  endtask

  task automatic t_shutdown();
    mode_therm = 4'b1111;
    pwm_in = 1'b1;
    expect_gap("R2", 3, 1'b1);
    mode_therm = 4'b0000;
    step();
    chk("R5", 2'b00);
    for (int i = 0; i < 6; i++) begin
      pwm_in = ~pwm_in;
      step();
      chk("R5", 2'b00);
    end
    mode_therm = 4'b0101;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R5", 2'b00);
    end
    pwm_in = 1'b1;
    mode_therm = 4'b0111;
    expect_gap("R6", 5, 1'b1);
    mode_therm = 4'b1011;
    step();
    chk("R5", 2'b00);
    step();
    chk("R5", 2'b00);
    mode_therm = 4'b1111;
    pwm_in = 1'b0;
    expect_gap("R6", 3, 1'b0);
  endtask

  initial begin
    step();
    t_reset();
    t_presets();
    t_no_shorten();
    t_toggle_back();
    t_shutdown();
    checks++;
    if (overlap_seen != 0) begin
      errors++;
      $display("FAIL R8: overlap cycles actual %0d expected 0", overlap_seen);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule